// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between memory locations on a simple single-master bus without CPU involvement. Each channel takes a bus slot only when it has a trigger to serve. For each unit it performs one read followed by one write, and then gives the bus back. A unit is 8 or 16 bits, chosen per channel. One side of a channel, either source or destination, may step forward through memory while the other side stays at a fixed address. Fixed-to-fixed is also allowed.

Software programs a source pointer, a destination pointer, a reload count and a control word for each channel, and then sets the run bit. The channel then serves one unit per trigger. The trigger is either a falling edge on an external line or a one-cycle pulse from a peripheral or from software, and a per-channel select input picks which. When the count runs out, the channel raises a one-cycle completion pulse. In one-shot mode the channel then stops. In auto-restart mode it reloads and keeps serving triggers.

Top module: `dmac_top`

## Requirements
- R1: After reset every channel register reads zero, the bus is idle (`mem_req_o` low) and `done_o` is low.
- R2: Each served trigger makes exactly one read at the source address, followed in the next bus slot by one write of the read data to the destination address. `mem_wide_o` is high for 16-bit units. The address is held while `mem_ready_i` is low.
- R3: After each unit the live forward pointer advances by 1 for 8-bit units or by 2 for 16-bit units, and the fixed side keeps its address. A control write that requests forward on both sides stores source-forward only (bit 3 reads back 0).
- R4: Setting the run bit from 0 copies the forward-side pointer into the live pointer and the reload value into the counter. A trigger that arrives while the run bit is 0 causes no transfer, including a trigger in the same cycle as the enabling write.
- R5: The counter drops by one per completed unit, and underflow means completing a unit while it holds 0, so a reload value N gives N+1 units. In one-shot mode an underflow clears the run bit, and later triggers cause no transfer.
- R6: In auto-restart mode an underflow reloads the counter from the reload register and the live pointer from the programmed forward pointer. The run bit stays 1.
- R7: When both channels have a request waiting as the bus becomes free, channel 0 is served first.
- R8: With `req_sel_i[c]`=0, channel c triggers only on a falling edge of `ext_req_ni[c]` and ignores `pulse_req_i[c]`. With `req_sel_i[c]`=1, each cycle of `pulse_req_i[c]` high is a trigger.
- R9: While the run bit is 1, writes to a fixed-side pointer are ignored. Writes to the forward-side pointer are accepted and take effect at the next start or reload. A control write changes only the run bit.
- R10: Register index is `reg_addr_i[2:0]` (0 source, 1 destination, 2 reload, 3 live counter (read only), 4 control) and the channel is `reg_addr_i[3]`. Control bits are: 0 run, 1 16-bit, 2 source forward, 3 destination forward, 4 auto-restart. While running, the forward-side pointer reads the live pointer. Otherwise it reads the programmed value.
- R11: Writing 0 to the run bit stops the channel and drops any waiting request, even one queued behind a transfer of the other channel.
- R12: `done_o[c]` pulses high for exactly one cycle on each underflow of channel c.
- R13: A trigger that arrives while the bus is busy is held and served after the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RA_W (4) | Channel and register index |
| reg_wdata_i | input | DW (16) | Register write data |
| reg_rdata_o | output | DW (16) | Register read data (combinational) |
| req_sel_i | input | NCH (2) | Per-channel trigger select: 0 edge, 1 pulse |
| ext_req_ni | input | NCH (2) | External triggers, active on falling edge |
| pulse_req_i | input | NCH (2) | Peripheral/software trigger pulses |
| mem_req_o | output | 1 | Bus access valid |
| mem_we_o | output | 1 | Bus access is a write |
| mem_wide_o | output | 1 | Access is 16-bit |
| mem_addr_o | output | AW (16) | Byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_ready_i | input | 1 | Access completes this cycle |
| done_o | output | NCH (2) | One-cycle completion pulse per channel |

## Verification
The assertions check the following on every cycle: a read is always followed by a write, the bus address holds during a stall, channel 0 wins arbitration, completion pulses last one cycle, a one-shot channel is stopped when its pulse appears, and no request waits on a stopped channel. The directed scenarios are needed for everything that depends on data or register values. These include the moved data and its width, the pointer step, the reload of counter and pointer in auto-restart mode, the write lock, the live-pointer readback, the edge-versus-pulse trigger choice, and a request being dropped by a stop while it waits behind another channel.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef struct packed {
    logic rep;
    logic dst_fwd;
    logic src_fwd;
    logic wide;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {BUS_IDLE, BUS_RD, BUS_WR} bus_st_e;

  localparam logic [2:0] IDX_SRC  = 3'd0;
  localparam logic [2:0] IDX_DST  = 3'd1;
  localparam logic [2:0] IDX_RLD  = 3'd2;
  localparam logic [2:0] IDX_CNT  = 3'd3;
  localparam logic [2:0] IDX_CTRL = 3'd4;
endpackage

// File: rtl/dmac_trig.sv
module dmac_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic ext_ni,
  input  logic pulse_i,
  output logic trig_o
);
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b1;
    else         ext_q <= ext_ni;
  end

  assign trig_o = sel_i ? pulse_i : (ext_q & ~ext_ni);
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan import dmac_pkg::*; #(
  parameter int AW    = 16,
  parameter int CNT_W = 16,
  parameter int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          trig_i,
  input  logic          grant_i,
  input  logic          xfer_done_i,
  output logic [DW-1:0] rdata_o,
  output logic          pend_o,
  output logic          en_o,
  output logic          rep_o,
  output logic          wide_o,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          done_o
);
  ctrl_t            ctrl_q, w_ctrl;
  logic [AW-1:0]    src_q, dst_q, fwd_q, base_cur, base_new, step;
  logic [CNT_W-1:0] rld_q, cnt_q;
  logic             pend_q, done_q, wr_ctrl, stop_w, last;

  always_comb begin
    w_ctrl         = ctrl_t'(wdata_i[4:0]);
    w_ctrl.dst_fwd = wdata_i[3] & ~wdata_i[2];  // never forward on both sides
  end

  assign wr_ctrl  = wr_i && idx_i == IDX_CTRL;
  assign stop_w   = wr_ctrl && !wdata_i[0];
  assign last     = xfer_done_i && ctrl_q.en && cnt_q == '0;
  assign base_cur = ctrl_q.src_fwd ? src_q : dst_q;
  assign base_new = w_ctrl.src_fwd ? src_q : dst_q;
  assign step     = ctrl_q.wide ? AW'(2) : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      fwd_q  <= '0;
      rld_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (xfer_done_i && ctrl_q.en) begin
        if (cnt_q == '0) begin
          if (ctrl_q.rep) begin
            cnt_q <= rld_q;
            fwd_q <= base_cur;
          end else begin
            ctrl_q.en <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
          fwd_q <= fwd_q + step;
        end
      end
      if (wr_i) begin
        case (idx_i)
          IDX_SRC: if (!ctrl_q.en || ctrl_q.src_fwd) src_q <= wdata_i[AW-1:0];
          IDX_DST: if (!ctrl_q.en || ctrl_q.dst_fwd) dst_q <= wdata_i[AW-1:0];
          IDX_RLD: rld_q <= wdata_i[CNT_W-1:0];
          IDX_CTRL: begin
            if (!ctrl_q.en) begin
              ctrl_q <= w_ctrl;
              if (w_ctrl.en) begin
                fwd_q <= base_new;
                cnt_q <= rld_q;
              end
            end else begin
              ctrl_q.en <= wdata_i[0];
            end
          end
          default: ;
        endcase
      end
      // requests only count while running, and after the run bit is set
      if (stop_w || (last && !ctrl_q.rep) || !ctrl_q.en) pend_q <= 1'b0;
      else if (trig_i)                                    pend_q <= 1'b1;
      else if (grant_i)                                   pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (idx_i)
      IDX_SRC:  rdata_o = DW'((ctrl_q.en && ctrl_q.src_fwd) ? fwd_q : src_q);
      IDX_DST:  rdata_o = DW'((ctrl_q.en && ctrl_q.dst_fwd) ? fwd_q : dst_q);
      IDX_RLD:  rdata_o = DW'(rld_q);
      IDX_CNT:  rdata_o = DW'(cnt_q);
      IDX_CTRL: rdata_o = DW'(ctrl_q);
      default:  rdata_o = '0;
    endcase
  end

  assign src_addr_o = ctrl_q.src_fwd ? fwd_q : src_q;
  assign dst_addr_o = ctrl_q.dst_fwd ? fwd_q : dst_q;
  assign pend_o     = pend_q;
  assign en_o       = ctrl_q.en;
  assign rep_o      = ctrl_q.rep;
  assign wide_o     = ctrl_q.wide;
  assign done_o     = done_q;
endmodule

// File: rtl/dmac_bus.sv
module dmac_bus import dmac_pkg::*; #(
  parameter int NCH  = 2,
  parameter int AW   = 16,
  parameter int CH_W = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH-1:0]         pend_i,
  input  logic [NCH-1:0][AW-1:0] src_addr_i,
  input  logic [NCH-1:0][AW-1:0] dst_addr_i,
  input  logic [NCH-1:0]         wide_i,
  input  logic                   mem_ready_i,
  input  logic [15:0]            mem_rdata_i,
  output logic [NCH-1:0]         grant_o,
  output logic [NCH-1:0]         xfer_done_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic                   mem_wide_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [15:0]            mem_wdata_o,
  output logic                   idle_o,
  output logic [CH_W-1:0]        ch_o
);
  bus_st_e         st_q;
  logic [CH_W-1:0] ch_q, pick;
  logic [15:0]     data_q;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) if (pend_i[i]) pick = CH_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BUS_IDLE;
      ch_q   <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        BUS_IDLE: if (|pend_i) begin
          ch_q <= pick;
          st_q <= BUS_RD;
        end
        BUS_RD: if (mem_ready_i) begin
          data_q <= mem_rdata_i;
          st_q   <= BUS_WR;
        end
        BUS_WR: if (mem_ready_i) st_q <= BUS_IDLE;
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  assign grant_o     = (st_q == BUS_IDLE && |pend_i) ? (NCH'(1) << pick) : '0;
  assign xfer_done_o = (st_q == BUS_WR && mem_ready_i) ? (NCH'(1) << ch_q) : '0;
  assign mem_req_o   = st_q != BUS_IDLE;
  assign mem_we_o    = st_q == BUS_WR;
  assign mem_wide_o  = wide_i[ch_q];
  assign mem_addr_o  = (st_q == BUS_WR) ? dst_addr_i[ch_q] : src_addr_i[ch_q];
  assign mem_wdata_o = wide_i[ch_q] ? data_q : {8'h00, data_q[7:0]};
  assign idle_o      = st_q == BUS_IDLE;
  assign ch_o        = ch_q;
endmodule

// File: rtl/dmac_top.sv
module dmac_top #(
  parameter int NCH   = 2,
  parameter int AW    = 16,
  parameter int CNT_W = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RA_W = CH_W + 3,
  localparam int DW   = (AW > CNT_W) ? AW : CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RA_W-1:0] reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic [NCH-1:0]  req_sel_i,
  input  logic [NCH-1:0]  ext_req_ni,
  input  logic [NCH-1:0]  pulse_req_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            mem_wide_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [15:0]     mem_wdata_o,
  input  logic [15:0]     mem_rdata_i,
  input  logic            mem_ready_i,
  output logic [NCH-1:0]  done_o
);
  logic [NCH-1:0]         ch_wr, ch_trig, ch_grant, ch_xdone;
  logic [NCH-1:0]         ch_pend, ch_en, ch_rep, ch_wide;
  logic [NCH-1:0][AW-1:0] ch_src, ch_dst;
  logic [NCH-1:0][DW-1:0] ch_rdata;
  logic                   bus_idle;
  logic [CH_W-1:0]        bus_ch;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_wr[c] = reg_we_i && reg_addr_i[RA_W-1:3] == CH_W'(c);

    dmac_trig u_trig (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (req_sel_i[c]),
      .ext_ni  (ext_req_ni[c]),
      .pulse_i (pulse_req_i[c]),
      .trig_o  (ch_trig[c])
    );

    dmac_chan #(.AW(AW), .CNT_W(CNT_W), .DW(DW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (ch_wr[c]),
      .idx_i       (reg_addr_i[2:0]),
      .wdata_i     (reg_wdata_i),
      .trig_i      (ch_trig[c]),
      .grant_i     (ch_grant[c]),
      .xfer_done_i (ch_xdone[c]),
      .rdata_o     (ch_rdata[c]),
      .pend_o      (ch_pend[c]),
      .en_o        (ch_en[c]),
      .rep_o       (ch_rep[c]),
      .wide_o      (ch_wide[c]),
      .src_addr_o  (ch_src[c]),
      .dst_addr_o  (ch_dst[c]),
      .done_o      (done_o[c])
    );
  end

  assign reg_rdata_o = ch_rdata[reg_addr_i[RA_W-1:3]];

  dmac_bus #(.NCH(NCH), .AW(AW), .CH_W(CH_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (ch_pend),
    .src_addr_i  (ch_src),
    .dst_addr_i  (ch_dst),
    .wide_i      (ch_wide),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .grant_o     (ch_grant),
    .xfer_done_o (ch_xdone),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_wide_o  (mem_wide_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .idle_o      (bus_idle),
    .ch_o        (bus_ch)
  );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int NCH  = 2,
  parameter int AW   = 16,
  parameter int CH_W = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_ready_i,
  input logic [AW-1:0]   mem_addr_o,
  input logic [NCH-1:0]  done_o,
  input logic [NCH-1:0]  pend,
  input logic [NCH-1:0]  ch_en,
  input logic [NCH-1:0]  ch_rep,
  input logic            bus_idle,
  input logic [CH_W-1:0] bus_ch
);
  // R2
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_req_o && mem_we_o));

  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R7
  ch0_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle && pend[0]) |=> (bus_ch == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R12
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[c] |=> !done_o[c]);

    // R5
    oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o[c] && !ch_rep[c]) |-> !ch_en[c]);

    // R4
    pend_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend[c] |-> ch_en[c]);
  end
endmodule

bind dmac_top dmac_chk #(.NCH(NCH), .AW(AW), .CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .done_o      (done_o),
  .pend        (ch_pend),
  .ch_en       (ch_en),
  .ch_rep      (ch_rep),
  .bus_idle    (bus_idle),
  .bus_ch      (bus_ch)
);

// File: tb/dmac_top_bench.sv
`timescale 1ns/1ps
module dmac_top_bench;
  localparam int I_SRC = 0, I_DST = 1, I_RLD = 2, I_CNT = 3, I_CTL = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [1:0]  req_sel_i = 2'b11;
  logic [1:0]  ext_req_ni = 2'b11;
  logic [1:0]  pulse_req_i = 2'b00;
  logic        mem_req_o, mem_we_o, mem_wide_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b1;
  logic [1:0]  done_o;

  logic [7:0]  mem [256];
  int          checks = 0, failures = 0, wr_cnt = 0;
  int          done_cnt [2];
  bit          finished = 0;

  always #10 clk = ~clk;

  dmac_top u_dmac_top (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .req_sel_i(req_sel_i),
    .ext_req_ni(ext_req_ni), .pulse_req_i(pulse_req_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_wide_o(mem_wide_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .done_o(done_o)
  );

  assign mem_rdata_i = {mem[8'(mem_addr_o[7:0] + 8'd1)], mem[mem_addr_o[7:0]]};

  always @(posedge clk) begin
    if (rst_ni && mem_req_o && mem_we_o && mem_ready_i) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o[7:0];
      if (mem_wide_o) mem[8'(mem_addr_o[7:0] + 8'd1)] <= mem_wdata_o[15:8];
      wr_cnt <= wr_cnt + 1;
    end
    for (int c = 0; c < 2; c++) if (done_o[c]) done_cnt[c] <= done_cnt[c] + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int idx, input int val);
    reg_addr_i  = 4'((ch << 3) | idx);
    reg_wdata_i = 16'(val);
    reg_we_i    = 1'b1;
    @(negedge clk);
    reg_we_i    = 1'b0;
  endtask

  task automatic rd(input int ch, input int idx, output int val);
    reg_addr_i = 4'((ch << 3) | idx);
    #1 val = int'(reg_rdata_o);
  endtask

  task automatic pulse(input logic [1:0] m);
    pulse_req_i = m;
    @(negedge clk);
    pulse_req_i = 2'b00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    rd(0, I_CTL, v); chk("R1 ctrl0", v, 0);
    rd(1, I_SRC, v); chk("R1 src1", v, 0);
    rd(1, I_RLD, v); chk("R1 rld1", v, 0);
    chk("R1 mem_req", int'(mem_req_o), 0);
    chk("R1 done", int'(done_o), 0);
  endtask

  task automatic t_oneshot;
    int v, w0;
    wr(0, I_SRC, 'h10); wr(0, I_DST, 'h80); wr(0, I_RLD, 2);
    pulse(2'b01); idle(6);
    chk("R4 no xfer before run", int'(mem[8'h80]), 0);
    wr(0, I_CTL, 'h05);
    rd(0, I_SRC, v); chk("R10 live src at start", v, 'h10);
    rd(0, I_CNT, v); chk("R4 counter loaded", v, 2);
    pulse(2'b01); idle(6);
    chk("R2 first byte", int'(mem[8'h80]), int'(mem[8'h10]));
    rd(0, I_SRC, v); chk("R3 step 1", v, 'h11);
    rd(0, I_CNT, v); chk("R5 count down", v, 1);
    pulse(2'b01); idle(6);
    pulse(2'b01); idle(6);
    chk("R5 third byte", int'(mem[8'h80]), int'(mem[8'h12]));
    rd(0, I_CTL, v); chk("R5 run cleared", v, 'h04);
    chk("R12 one done", done_cnt[0], 1);
    rd(0, I_SRC, v); chk("R10 programmed src", v, 'h10);
    w0 = wr_cnt;
    pulse(2'b01); idle(6);
    chk("R5 stopped", wr_cnt, w0);
  endtask

  task automatic t_wide;
    int v;
    wr(1, I_SRC, 'h20); wr(1, I_DST, 'h40); wr(1, I_RLD, 1);
    wr(1, I_CTL, 'h0B);
    pulse(2'b10); idle(6);
    chk("R2 wide lo", int'(mem[8'h40]), int'(mem[8'h20]));
    chk("R2 wide hi", int'(mem[8'h41]), int'(mem[8'h21]));
    rd(1, I_DST, v); chk("R3 step 2", v, 'h42);
    rd(1, I_SRC, v); chk("R3 fixed src", v, 'h20);
    pulse(2'b10); idle(6);
    chk("R3 second word", int'(mem[8'h43]), int'(mem[8'h21]));
    chk("R12 ch1 done", done_cnt[1], 1);
    rd(1, I_CTL, v); chk("R5 ch1 stopped", v, 'h0A);
  endtask

  task automatic t_both_fwd;
    int v;
    wr(0, I_CTL, 'h0C);
    rd(0, I_CTL, v); chk("R3 both-forward rejected", v, 'h04);
  endtask

  task automatic t_repeat_lock;
    int v, d0, w0;
    wr(0, I_SRC, 'h10); wr(0, I_DST, 'h90); wr(0, I_RLD, 1);
    wr(0, I_CTL, 'h15);
    d0 = done_cnt[0];
    pulse(2'b01); idle(6);
    pulse(2'b01); idle(6);
    chk("R6 done on wrap", done_cnt[0], d0 + 1);
    rd(0, I_CTL, v); chk("R6 still running", v, 'h15);
    rd(0, I_CNT, v); chk("R6 count reloaded", v, 1);
    rd(0, I_SRC, v); chk("R6 pointer reloaded", v, 'h10);
    pulse(2'b01); idle(6);
    chk("R6 restart data", int'(mem[8'h90]), int'(mem[8'h10]));
    wr(0, I_DST, 'hAA);
    rd(0, I_DST, v); chk("R9 fixed locked", v, 'h90);
    wr(0, I_CTL, 'h17);
    rd(0, I_CTL, v); chk("R9 ctrl locked", v, 'h15);
    wr(0, I_SRC, 'h30);
    rd(0, I_SRC, v); chk("R10 live read", v, 'h11);
    pulse(2'b01); idle(6);
    chk("R9 dst unchanged", int'(mem[8'h90]), int'(mem[8'h11]));
    chk("R9 no stray write", int'(mem[8'hAA]), 0);
    chk("R12 second wrap", done_cnt[0], d0 + 2);
    rd(0, I_SRC, v); chk("R9 fwd write at reload", v, 'h30);
    wr(0, I_CTL, 'h00);
    rd(0, I_CTL, v); chk("R11 stop", v, 'h14);
    w0 = wr_cnt;
    pulse(2'b01); idle(6);
    chk("R11 no xfer after stop", wr_cnt, w0);
  endtask

  task automatic t_priority;
    int v, a;
    wr(0, I_SRC, 'h12); wr(0, I_DST, 'hA0); wr(0, I_RLD, 0); wr(0, I_CTL, 'h01);
    wr(1, I_SRC, 'h22); wr(1, I_DST, 'hA2); wr(1, I_RLD, 0); wr(1, I_CTL, 'h01);
    pulse(2'b11);
    a = -1;
    for (int k = 0; k < 4; k++) begin
      if (a < 0 && mem_req_o && !mem_we_o) a = int'(mem_addr_o);
      @(negedge clk);
    end
    chk("R7 ch0 first", a, 'h12);
    idle(10);
    chk("R7 ch0 data", int'(mem[8'hA0]), int'(mem[8'h12]));
    chk("R13 ch1 held", int'(mem[8'hA2]), int'(mem[8'h22]));
    rd(1, I_CTL, v); chk("R5 ch1 done", v, 0);
  endtask

  task automatic t_edge;
    int w0;
    req_sel_i[1] = 1'b0;
    wr(1, I_SRC, 'h24); wr(1, I_DST, 'hA4); wr(1, I_RLD, 10); wr(1, I_CTL, 'h01);
    w0 = wr_cnt;
    ext_req_ni[1] = 1'b0; idle(8);
    chk("R8 falling edge", wr_cnt, w0 + 1);
    idle(8);
    chk("R8 low level", wr_cnt, w0 + 1);
    ext_req_ni[1] = 1'b1; idle(8);
    chk("R8 rising edge", wr_cnt, w0 + 1);
    pulse(2'b10); idle(8);
    chk("R8 pulse ignored", wr_cnt, w0 + 1);
    ext_req_ni[1] = 1'b0; idle(8);
    chk("R8 second edge", wr_cnt, w0 + 2);
    ext_req_ni[1] = 1'b1;
    wr(1, I_CTL, 'h00);
    req_sel_i[1] = 1'b1;
    idle(2);
  endtask

  task automatic t_stop_pending;
    wr(1, I_SRC, 'h26); wr(1, I_DST, 'hA6); wr(1, I_RLD, 0); wr(1, I_CTL, 'h01);
    wr(0, I_SRC, 'h28); wr(0, I_DST, 'hB0); wr(0, I_RLD, 0); wr(0, I_CTL, 'h01);
    mem_ready_i = 1'b0;
    pulse(2'b10); idle(2);
    chk("R2 stall read", int'(mem_req_o && !mem_we_o), 1);
    chk("R2 stall addr", int'(mem_addr_o), 'h26);
    pulse(2'b01);
    wr(0, I_CTL, 'h00);
    mem_ready_i = 1'b1;
    idle(10);
    chk("R13 ch1 done", int'(mem[8'hA6]), int'(mem[8'h26]));
    chk("R11 pending dropped", int'(mem[8'hB0]), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i < 'h80) ? 8'(i * 3 + 1) : 8'h00;
    done_cnt[0] = 0; done_cnt[1] = 0;
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_oneshot();
    t_wide();
    t_both_fwd();
    t_repeat_lock();
    t_priority();
    t_edge();
    t_stop_pending();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule